// File: doc/BRIEF.md
# Handshake Pipeline Stage

This block sits on one VALID/READY channel between a sender and a receiver and cuts every timing path that would otherwise run straight through it. The payload is carried unchanged; its width is a parameter. Every signal the block drives comes straight from a flip-flop, so the logic that produces the sender's signals and the logic that consumes the receiver's signals never share a combinational path.

A mode parameter picks one of two builds. The half-rate build keeps one stored item and takes a new one at most on every second cycle. The full-rate build adds a spare holding register. It can take one item on every cycle and adds no bubble. In both builds an item taken while the output register is free appears at the output on the next cycle. In the full-rate build an incoming item skips the spare register whenever the output can take it. The spare register only catches an item that arrives while the output is stalled.

Top module: `axi_reg_slice`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `m_valid` and `s_ready` are both low.
- R2: In either mode, an item taken (`s_valid` and `s_ready` high) while the output register is empty or being drained is shown on `m_data` with `m_valid` high in the very next cycle.
- R3: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` keeps its value in the next cycle.
- R4: In half-rate mode (`MODE` = `SLICE_HALF`), `s_ready` is low in the cycle after any accepted item, so a continuous stream of 16 items with `m_ready` held high takes 31 clock edges from the first acceptance to the last.
- R5: In full-rate mode (`MODE` = `SLICE_FULL`), `s_ready` stays high while `m_ready` is high, so a continuous stream of 16 items is accepted on 16 consecutive edges.
- R6: In full-rate mode, with the output stalled, one more item is caught in the spare register and `s_ready` then drops. When the receiver takes the first item, the caught item moves to `m_data` and `s_ready` rises again on the same edge.
- R7: Under any pattern of `m_ready`, every accepted item leaves exactly once, in acceptance order, and no item leaves that was not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sender offers an item |
| s_ready | output | 1 | Block can take an item (registered) |
| s_data | input | W | Payload from the sender |
| m_valid | output | 1 | Block offers an item (registered) |
| m_ready | input | 1 | Receiver takes the item |
| m_data | output | W | Payload to the receiver (registered) |

## Verification
The assertions assume the sender follows the channel rule: once `s_valid` is high it holds the same `s_data` until `s_ready` takes it. The latency and ordering properties depend on this. The driver task keeps one item on the inputs, with `s_valid` high, until the cycle in which it sees `s_ready`, and only then moves on. The receiver side is left free: `m_ready` is driven high, driven low, or driven from a pseudo-random pattern, and it may drop in any cycle.

// File: rtl/slice_pkg.sv
package slice_pkg;

    typedef enum logic {
        SLICE_HALF = 1'b0,
        SLICE_FULL = 1'b1
    } slice_mode_e;

    // number of items the slice can hold in a given mode
    function automatic int unsigned stage_count(slice_mode_e m);
        return (m == SLICE_FULL) ? 2 : 1;
    endfunction

endpackage

// File: rtl/slice_hold_reg.sv
module slice_hold_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/slice_half_ctl.sv
module slice_half_ctl #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_data,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [W-1:0] m_data
);
    typedef struct packed {
        logic full;
        logic rdy;
    } half_state_t;

    half_state_t st_q, st_d;
    logic        take;

    assign take = s_valid && st_q.rdy;

    always_comb begin
        st_d.full = take ? 1'b1 : (st_q.full && !m_ready);
        st_d.rdy  = !st_d.full;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    slice_hold_reg #(.W(W)) u_out (
        .clk(clk), .rst(rst), .load(take), .d(s_data), .q(m_data)
    );

    assign m_valid = st_q.full;
    assign s_ready = st_q.rdy;
endmodule

// File: rtl/slice_full_ctl.sv
module slice_full_ctl #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_data,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [W-1:0] m_data
);
    typedef struct packed {
        logic out_full;
        logic spare_full;
        logic rdy;
    } full_state_t;

    full_state_t  st_q, st_d;
    logic         take, out_free;
    logic         ld_out, ld_spare, from_spare;
    logic [W-1:0] spare_q, out_d;

    assign take     = s_valid && st_q.rdy;
    assign out_free = !st_q.out_full || m_ready;

    always_comb begin
        st_d       = st_q;
        ld_out     = 1'b0;
        ld_spare   = 1'b0;
        from_spare = 1'b0;
        if (out_free) begin
            if (st_q.spare_full) begin
                st_d.out_full   = 1'b1;
                st_d.spare_full = 1'b0;
                ld_out          = 1'b1;
                from_spare      = 1'b1;
            end else if (take) begin
                st_d.out_full = 1'b1;
                ld_out        = 1'b1;
            end else begin
                st_d.out_full = 1'b0;
            end
        end else if (take) begin
            st_d.spare_full = 1'b1;
            ld_spare        = 1'b1;
        end
        st_d.rdy = !st_d.spare_full;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_d = from_spare ? spare_q : s_data;

    slice_hold_reg #(.W(W)) u_spare (
        .clk(clk), .rst(rst), .load(ld_spare), .d(s_data), .q(spare_q)
    );

    slice_hold_reg #(.W(W)) u_out (
        .clk(clk), .rst(rst), .load(ld_out), .d(out_d), .q(m_data)
    );

    assign m_valid = st_q.out_full;
    assign s_ready = st_q.rdy;
endmodule

// File: rtl/axi_reg_slice.sv
module axi_reg_slice #(
    parameter slice_pkg::slice_mode_e MODE = slice_pkg::SLICE_FULL,
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_data,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [W-1:0] m_data
);
    generate
        if (MODE == slice_pkg::SLICE_FULL) begin : g_full
            slice_full_ctl #(.W(W)) u_ctl (
                .clk(clk), .rst(rst),
                .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
                .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
            );
        end else begin : g_half
            slice_half_ctl #(.W(W)) u_ctl (
                .clk(clk), .rst(rst),
                .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
                .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
            );
        end
    endgenerate
endmodule

// File: rtl/axi_reg_slice_chk.sv
module axi_reg_slice_chk #(
    parameter slice_pkg::slice_mode_e MODE = slice_pkg::SLICE_FULL,
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         s_valid,
    input logic         s_ready,
    input logic [W-1:0] s_data,
    input logic         m_valid,
    input logic         m_ready,
    input logic [W-1:0] m_data
);
    localparam int unsigned CAP = slice_pkg::stage_count(MODE);

    logic [2:0] occ;
    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + 3'(s_valid && s_ready) - 3'(m_valid && m_ready);
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!m_valid && !s_ready));

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready && (!m_valid || m_ready)) |=> (m_valid && m_data == $past(s_data)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R7: no loss or duplication, occupancy bounded by the storage
    p_occupancy_r7: assert property (@(posedge clk) disable iff (rst)
        (occ <= 3'(CAP)) && (m_valid == (occ != 3'd0)));

    generate
        if (MODE == slice_pkg::SLICE_HALF) begin : g_half_props
            p_half_gap_r4: assert property (@(posedge clk) disable iff (rst)
                (s_valid && s_ready) |=> !s_ready);
        end else begin : g_full_props
            p_full_rate_r5: assert property (@(posedge clk) disable iff (rst)
                (s_ready && m_ready) |=> s_ready);
            p_stall_block_r6: assert property (@(posedge clk) disable iff (rst)
                (s_valid && s_ready && m_valid && !m_ready) |=> !s_ready);
        end
    endgenerate
endmodule

bind axi_reg_slice axi_reg_slice_chk #(.MODE(MODE), .W(W)) u_chk (
    .clk(clk), .rst(rst),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
);

// File: tb/axi_reg_slice_test.sv
module slice_env #(
    parameter slice_pkg::slice_mode_e MODE = slice_pkg::SLICE_FULL,
    parameter int W = 16
) (
    input logic clk
);
    logic         rst, s_valid, s_ready, m_valid, m_ready;
    logic [W-1:0] s_data, m_data;
    int           total = 0, bad = 0, cyc = 0;
    bit           done = 0;
    logic [1:0]   bp = 2'd0;
    logic [7:0]   lfsr = 8'h5B;
    logic [W-1:0] exp_q[$];
    bit           prev_stall = 0, prev_acc = 0;
    logic [W-1:0] prev_data = '0;

    axi_reg_slice #(.MODE(MODE), .W(W)) uut (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
    );

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    assign m_ready = (bp == 2'd0) || (bp == 2'd1 && (lfsr[0] ^ lfsr[3]));

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s mode=%0d act=%0h exp=%0h", req, MODE, act, expv);
        end
    endtask

    task automatic send(logic [W-1:0] d);
        bit got;
        s_valid = 1'b1;
        s_data  = d;
        do begin
            @(negedge clk);
            got = s_ready;
            if (got) exp_q.push_back(d);
            @(posedge clk); #1;
        end while (!got);
    endtask

    task automatic idle(int n);
        s_valid = 1'b0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) chk(0, "R7 extra item", int'(m_data), 0);
                else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(m_data == e, "R7 order", int'(m_data), int'(e));
                end
            end
            if (prev_stall) chk(m_valid && m_data == prev_data, "R3 hold", int'(m_data), int'(prev_data));
            if (MODE == slice_pkg::SLICE_HALF && prev_acc) chk(!s_ready, "R4 gap", int'(s_ready), 0);
            prev_stall = m_valid && !m_ready;
            prev_data  = m_data;
            prev_acc   = s_valid && s_ready;
        end else begin
            prev_stall = 0;
            prev_acc   = 0;
        end
    end

    initial begin
        int t0;
        rst = 1'b1; s_valid = 1'b0; s_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!m_valid && !s_ready, "R1 in reset", {m_valid, s_ready}, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!m_valid && !s_ready, "R1 after reset", {m_valid, s_ready}, 0);
        @(posedge clk); #1;

        // R2 single item latency
        send(16'hA5A1);
        s_valid = 1'b0;
        @(negedge clk);
        chk(m_valid && m_data == 16'hA5A1, "R2 latency", int'(m_data), 16'hA5A1);
        @(posedge clk); #1;
        idle(3);

        // R4 / R5 streaming rate
        t0 = cyc;
        for (int i = 0; i < 16; i++) send(16'h1000 + 16'(i));
        if (MODE == slice_pkg::SLICE_FULL) chk(cyc - t0 == 16, "R5 rate", cyc - t0, 16);
        else                               chk(cyc - t0 == 31, "R4 rate", cyc - t0, 31);
        idle(4);

        // stalled output
        bp = 2'd2;
        send(16'hB001);
        if (MODE == slice_pkg::SLICE_FULL) begin
            send(16'hB002);
            s_valid = 1'b0;
            @(negedge clk);
            chk(!s_ready && m_valid && m_data == 16'hB001, "R6 spare full", int'(m_data), 16'hB001);
            @(posedge clk); #1;
            bp = 2'd0;
            @(negedge clk);
            @(negedge clk);
            chk(s_ready && m_valid && m_data == 16'hB002, "R6 spare moved", int'(m_data), 16'hB002);
            @(posedge clk); #1;
        end else begin
            s_valid = 1'b0;
            repeat (3) begin
                @(negedge clk);
                chk(!s_ready && m_data == 16'hB001, "R4 stalled", int'(s_ready), 0);
                @(posedge clk); #1;
            end
            bp = 2'd0;
        end
        idle(4);

        // random backpressure with gaps
        bp = 2'd1;
        for (int i = 0; i < 80; i++) begin
            send(16'h4000 + 16'(i * 7));
            if (i % 9 == 4) idle(2);
        end
        s_valid = 1'b0;
        bp = 2'd0;
        idle(8);
        chk(exp_q.size() == 0 && !m_valid, "R7 drained", exp_q.size(), 0);
        done = 1;
    end
endmodule

module axi_reg_slice_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    slice_env #(.MODE(slice_pkg::SLICE_FULL), .W(16)) e_full (.clk(clk));
    slice_env #(.MODE(slice_pkg::SLICE_HALF), .W(16)) e_half (.clk(clk));

    initial begin
        int timeout_fail;
        timeout_fail = 0;
        for (int n = 0; n < 20000; n++) begin
            @(posedge clk);
            if (e_full.done && e_half.done) break;
        end
        if (!(e_full.done && e_half.done)) begin
            timeout_fail = 1;
            $display("FAIL watchdog expired act=0 exp=1");
        end
        $display("  test done: total=%0d bad=%0d",
                 e_full.total + e_half.total + timeout_fail,
                 e_full.bad + e_half.bad + timeout_fail);
        $finish;
    end
endmodule